// File: doc/BRIEF.md
# MII PHY Management Register File

This block models the management register set of a Fast Ethernet PHY, reached through an indirect address/data scheme. A host first loads a target word that names a PHY address and a register number. It then issues write strobes or read strobes, and these act on that target. The block answers only to its own PHY address, which is fixed by a parameter. A read aimed at any other address returns a floating bus of all ones, and a write aimed at one does nothing.

The block stores the control and advertisement registers. The status word and the link-partner ability word are built from a link-up input pin. A change on that pin shows in the next read without any reset. Two identifier words come from elaboration-time parameters. Setting the top bit of a control write acts as a software reset that reloads the defaults instead of storing the written value. Register numbers the block does not store read as zero. Serial bit-level management framing and real auto-negotiation are outside this block.

Top module: `mii_mgmt_regfile`

## Requirements
- R1: After the synchronous reset, control (register 0) reads 0x3100 and advertisement (register 4) reads 0x01E1; rd_valid is 0 and rd_data is 0.
- R2: When the target PHY address differs from PHY_ADDR, a read returns 0xFFFF and a write leaves every register unchanged.
- R3: A control write with bit 15 set reloads control to 0x3100 and advertisement to 0x01E1, and does not store the written value.
- R4: A control write with bit 15 clear stores the written value, and a later read returns it.
- R5: The advertisement register (number 4) stores any written value and returns it on read.
- R6: Status (register 1) reads 0x7848 with the link down and 0x786C with the link up (bit 2 link status, bit 5 negotiation complete).
- R7: Partner ability (register 5) reads 0x01E1 with the link up and 0x0080 with the link down.
- R8: Writes to registers 1, 2, 3, 5 and 6 have no effect on what any register reads back.
- R9: Registers 2 and 3 return the ID_HI and ID_LO parameters.
- R10: Any register number other than 0 to 5 reads as 0x0000.
- R11: The target word carries the PHY address in bits [15:8] and the register number in bits [7:0]. A read strobe in cycle k gives rd_data and a one-cycle rd_valid pulse after the clock edge that ends cycle k.
- R12: A change on link_up is seen by the next read of status or partner ability, with no reset in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Current link state from the line side |
| tgt_we | input | 1 | Load the target word |
| tgt_wdata | input | 16 | Target word: PHY address [15:8], register number [7:0] |
| wr_en | input | 1 | Write strobe for the targeted register |
| wr_data | input | 16 | Data for the write strobe |
| rd_en | input | 1 | Read strobe for the targeted register |
| rd_data | output | 16 | Registered read result |
| rd_valid | output | 1 | One-cycle pulse that marks rd_data as fresh |

## Verification
The bench aims at the points where the decode is easy to get wrong. A foreign PHY address must read 0xFFFF and not 0, and a write to it must not leak into the local registers. A control write with the reset bit must reload the advertisement register as well as control, and must not keep the written value. Writes to the read-only numbers must not reach the stored registers, and a mux that fell through to a stored register would show that. The link pin is toggled between reads with no reset, to catch status or partner bits that are latched only at reset.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int DATA_W = 16;

  // register numbers
  localparam int RN_CTRL   = 0;
  localparam int RN_STAT   = 1;
  localparam int RN_ID_HI  = 2;
  localparam int RN_ID_LO  = 3;
  localparam int RN_ADV    = 4;
  localparam int RN_PART   = 5;
  localparam int RN_EXPAN  = 6;

  // control bits
  localparam logic [DATA_W-1:0] CTL_SWRESET = 16'h8000;
  localparam logic [DATA_W-1:0] CTL_SPD100  = 16'h2000;
  localparam logic [DATA_W-1:0] CTL_ANEN    = 16'h1000;
  localparam logic [DATA_W-1:0] CTL_FDX     = 16'h0100;
  localparam logic [DATA_W-1:0] CTL_DEFAULT = CTL_SPD100 | CTL_ANEN | CTL_FDX;

  // ability bits shared by advertisement and partner words
  localparam logic [DATA_W-1:0] AB_TXFD  = 16'h0100;
  localparam logic [DATA_W-1:0] AB_TX    = 16'h0080;
  localparam logic [DATA_W-1:0] AB_10FD  = 16'h0040;
  localparam logic [DATA_W-1:0] AB_10    = 16'h0020;
  localparam logic [DATA_W-1:0] AB_SEL   = 16'h0001;
  localparam logic [DATA_W-1:0] ADV_DEFAULT = AB_TXFD | AB_TX | AB_10FD | AB_10 | AB_SEL;
  localparam logic [DATA_W-1:0] PART_DOWN   = AB_TX;
  localparam logic [DATA_W-1:0] PART_UP     = AB_TX | AB_TXFD | AB_10FD | AB_10 | AB_SEL;

  // status bits
  localparam logic [DATA_W-1:0] ST_TXFD  = 16'h4000;
  localparam logic [DATA_W-1:0] ST_TXHD  = 16'h2000;
  localparam logic [DATA_W-1:0] ST_10FD  = 16'h1000;
  localparam logic [DATA_W-1:0] ST_10HD  = 16'h0800;
  localparam logic [DATA_W-1:0] ST_PRSUP = 16'h0040;
  localparam logic [DATA_W-1:0] ST_ANCMP = 16'h0020;
  localparam logic [DATA_W-1:0] ST_ANABL = 16'h0008;
  localparam logic [DATA_W-1:0] ST_LINK  = 16'h0004;
  localparam logic [DATA_W-1:0] ST_BASE  =
    ST_TXFD | ST_TXHD | ST_10FD | ST_10HD | ST_PRSUP | ST_ANABL;

  localparam logic [DATA_W-1:0] FLOAT_ONES = '1;
endpackage

// File: rtl/mgmt_target.sv
module mgmt_target #(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [2*ADDR_W-1:0] word,
  output logic [ADDR_W-1:0]   phy_sel,
  output logic [ADDR_W-1:0]   reg_sel
);
  // PHY address lives in the upper field, register number in the lower
  always_ff @(posedge clk) begin
    if (rst) begin
      phy_sel <= '0;
      reg_sel <= '0;
    end else if (load) begin
      phy_sel <= word[2*ADDR_W-1:ADDR_W];
      reg_sel <= word[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/mgmt_ctrl_regs.sv
module mgmt_ctrl_regs
  import mii_mgmt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [ADDR_W-1:0] reg_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] adv_q
);
  logic is_ctrl, is_adv, sw_reset;

  assign is_ctrl  = (reg_sel == ADDR_W'(RN_CTRL));
  assign is_adv   = (reg_sel == ADDR_W'(RN_ADV));
  assign sw_reset = wr_hit && is_ctrl && ((wr_data & CTL_SWRESET) != '0);

  always_ff @(posedge clk) begin
    if (rst || sw_reset) begin
      ctrl_q <= CTL_DEFAULT;
      adv_q  <= ADV_DEFAULT;
    end else if (wr_hit) begin
      if (is_ctrl) ctrl_q <= wr_data;
      if (is_adv)  adv_q  <= wr_data;
    end
  end

  // R3: reset bit reloads both stored registers
  a_r3_swreset_reload: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && is_ctrl && wr_data[DATA_W-1]) |=>
      (ctrl_q == CTL_DEFAULT && adv_q == ADV_DEFAULT));

  // R8: writes to any other number leave stored registers untouched
  a_r8_readonly_stable: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && !is_ctrl && !is_adv) |=> ($stable(ctrl_q) && $stable(adv_q)));

  // R4: plain control write stores the value
  a_r4_ctrl_store: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && is_ctrl && !wr_data[DATA_W-1]) |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/mgmt_link_view.sv
module mgmt_link_view
  import mii_mgmt_pkg::*;
(
  input  logic              link_up,
  output logic [DATA_W-1:0] status_w,
  output logic [DATA_W-1:0] partner_w
);
  always_comb begin
    status_w  = ST_BASE;
    partner_w = PART_DOWN;
    if (link_up) begin
      status_w  = ST_BASE | ST_LINK | ST_ANCMP;
      partner_w = PART_UP;
    end
  end
endmodule

// File: rtl/mii_mgmt_regfile.sv
module mii_mgmt_regfile
  import mii_mgmt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PHY_ADDR = 8'd1,
  parameter logic [15:0]       ID_HI    = 16'h0D1A,
  parameter logic [15:0]       ID_LO    = 16'h7C21
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                link_up,
  input  logic                tgt_we,
  input  logic [2*ADDR_W-1:0] tgt_wdata,
  input  logic                wr_en,
  input  logic [15:0]         wr_data,
  input  logic                rd_en,
  output logic [15:0]         rd_data,
  output logic                rd_valid
);
  logic [ADDR_W-1:0] phy_sel, reg_sel;
  logic [DATA_W-1:0] ctrl_q, adv_q, status_w, partner_w;
  logic              phy_match;
  logic [DATA_W-1:0] rd_next;

  mgmt_target #(.ADDR_W(ADDR_W)) u_target (
    .clk(clk), .rst(rst), .load(tgt_we), .word(tgt_wdata),
    .phy_sel(phy_sel), .reg_sel(reg_sel)
  );

  assign phy_match = (phy_sel == PHY_ADDR);

  mgmt_ctrl_regs #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_en && phy_match), .reg_sel(reg_sel),
    .wr_data(wr_data), .ctrl_q(ctrl_q), .adv_q(adv_q)
  );

  mgmt_link_view u_link (
    .link_up(link_up), .status_w(status_w), .partner_w(partner_w)
  );

  always_comb begin
    rd_next = '0;
    if (!phy_match) begin
      rd_next = FLOAT_ONES;
    end else begin
      case (reg_sel)
        ADDR_W'(RN_CTRL):  rd_next = ctrl_q;
        ADDR_W'(RN_STAT):  rd_next = status_w;
        ADDR_W'(RN_ID_HI): rd_next = ID_HI;
        ADDR_W'(RN_ID_LO): rd_next = ID_LO;
        ADDR_W'(RN_ADV):   rd_next = adv_q;
        ADDR_W'(RN_PART):  rd_next = partner_w;
        default:           rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  // R11: one-cycle valid after each read strobe
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  a_r11_valid_quiet: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R2: foreign address floats high
  a_r2_foreign_ones: assert property (@(posedge clk) disable iff (rst)
    (rd_en && tgt_wdata == tgt_wdata && phy_sel != PHY_ADDR) |=> (rd_data == 16'hFFFF));

  // R6: link bit of status tracks the pin at read time
  a_r6_status_link: assert property (@(posedge clk) disable iff (rst)
    (rd_en && phy_match && reg_sel == ADDR_W'(RN_STAT)) |=> (rd_data[2] == $past(link_up)));
endmodule

// File: tb/mii_mgmt_regfile_tb.sv
module mii_mgmt_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IDH = 16'h0D1A;
  localparam logic [15:0] IDL = 16'h7C21;
  localparam int NV = 21;

  // {link, is_write, phy, reg, wdata, expected read}
  localparam logic [49:0] VECS [0:NV-1] = '{
    {1'b1, 1'b0, 8'd1, 8'd0,  16'h0000, 16'h3100}, // R1 control default
    {1'b1, 1'b0, 8'd1, 8'd4,  16'h0000, 16'h01E1}, // R1 adv default
    {1'b1, 1'b0, 8'd1, 8'd1,  16'h0000, 16'h786C}, // R6 link up
    {1'b1, 1'b0, 8'd1, 8'd5,  16'h0000, 16'h01E1}, // R7 link up
    {1'b1, 1'b0, 8'd1, 8'd2,  16'h0000, IDH},      // R9
    {1'b1, 1'b0, 8'd1, 8'd3,  16'h0000, IDL},      // R9
    {1'b1, 1'b0, 8'd1, 8'd7,  16'h0000, 16'h0000}, // R10
    {1'b1, 1'b0, 8'd1, 8'h1F, 16'h0000, 16'h0000}, // R10
    {1'b1, 1'b1, 8'd1, 8'd4,  16'h0061, 16'h0061}, // R5
    {1'b1, 1'b1, 8'd1, 8'd0,  16'h1200, 16'h1200}, // R4
    {1'b1, 1'b1, 8'd2, 8'd0,  16'h0000, 16'hFFFF}, // R2 foreign
    {1'b1, 1'b0, 8'd1, 8'd0,  16'h0000, 16'h1200}, // R2 no leak
    {1'b1, 1'b1, 8'd1, 8'd1,  16'h0000, 16'h786C}, // R8 status
    {1'b1, 1'b1, 8'd1, 8'd5,  16'h0000, 16'h01E1}, // R8 partner
    {1'b1, 1'b1, 8'd1, 8'd2,  16'h0000, IDH},      // R8 id
    {1'b0, 1'b0, 8'd1, 8'd1,  16'h0000, 16'h7848}, // R6 R12 link down
    {1'b0, 1'b0, 8'd1, 8'd5,  16'h0000, 16'h0080}, // R7 link down
    {1'b0, 1'b1, 8'd1, 8'd0,  16'h8000, 16'h3100}, // R3 reload control
    {1'b0, 1'b0, 8'd1, 8'd4,  16'h0000, 16'h01E1}, // R3 reload adv
    {1'b0, 1'b1, 8'd2, 8'd4,  16'h0000, 16'hFFFF}, // R2 foreign write
    {1'b0, 1'b0, 8'd1, 8'd4,  16'h0000, 16'h01E1}  // R2 adv untouched
  };

  logic clk = 1'b0, rst = 1'b1, link_up = 1'b1;
  logic tgt_we = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] tgt_wdata = '0, wr_data = '0, rd_data;
  logic rd_valid;
  int checks = 0, failures = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mii_mgmt_regfile #(.ADDR_W(8), .PHY_ADDR(8'd1), .ID_HI(IDH), .ID_LO(IDL)) u_dut (
    .clk(clk), .rst(rst), .link_up(link_up), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_target(input logic [7:0] phy, input logic [7:0] rn);
    @(negedge clk); tgt_we = 1'b1; tgt_wdata = {phy, rn};
    @(negedge clk); tgt_we = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // strobe one cycle, result sampled at the following negedge (R11)
  task automatic do_read(output logic [15:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  initial begin
    logic [15:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_valid after reset", {15'd0, rd_valid}, 16'h0000);
    check("R1 rd_data after reset", rd_data, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      link_up = VECS[i][49];
      set_target(VECS[i][47:40], VECS[i][39:32]);
      if (VECS[i][48]) do_write(VECS[i][31:16]);
      do_read(d, v);
      check($sformatf("vector %0d (R1..R10 per table)", i), d, VECS[i][15:0]);
      check("R11 valid pulse", {15'd0, v}, 16'h0001);
    end

    // R11: valid drops the cycle after
    @(negedge clk);
    check("R11 valid one cycle", {15'd0, rd_valid}, 16'h0000);

    // R12: raise link again without reset, read status and partner at once
    set_target(8'd1, 8'd1);
    link_up = 1'b1;
    do_read(d, v);
    check("R12 status after link rise", d, 16'h786C);
    set_target(8'd1, 8'd5);
    do_read(d, v);
    check("R12 partner after link rise", d, 16'h01E1);
    link_up = 1'b0;
    do_read(d, v);
    check("R12 partner after link fall", d, 16'h0080);

    // R11: field positions, PHY in upper byte
    set_target(8'd0, 8'd1);
    do_read(d, v);
    check("R11 swapped fields read foreign", d, 16'hFFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule